// File: doc/BRIEF.md
# Sprite Table Copy Engine

This block copies a 160-byte page from a source chosen by the CPU into sprite attribute memory. A CPU write to its start register stores the source page and arms the engine. The engine waits until the shared 4-phase machine cycle counter it receives reaches phase 3, then moves one byte every four clocks. For each byte it reads the shared bus at `{page, index}` and writes the byte to attribute memory at `0xFE00 + index`.

While the engine is armed or copying, it holds a single ownership flag high. The surrounding fabric uses this flag to hand the shared bus and the attribute memory port to the engine. The engine never writes to the shared bus. If the CPU writes the start register again while a copy is under way, the copy starts over from index 0 with the newly written page.

Top module: `sprite_dma`

## Requirements
- R1: After reset `own_o`, `bus_rd_o`, `bus_wr_o` and `oam_wr_o` are low and `reg_rdata_o` is 0x00.
- R2: A write on `reg_wr_i` stores `reg_wdata_i` as the page. From the next clock, `reg_rdata_o` returns that value and `own_o` is high.
- R3: After a trigger, `bus_rd_o` first rises on the clock after an edge at which `phase_i` equals 3.
- R4: Each byte takes four clocks. In the first two, `bus_rd_o` is high and `bus_addr_o = {page, index}`. In the third, `oam_wr_o` is high and `oam_wdata_o` carries the byte that was on `bus_din_i` in the second clock. The fourth clock is idle.
- R5: `oam_addr_o` equals 0xFE00 plus the byte index. Indices run upward from 0.
- R6: Exactly 160 bytes (indices 0 to 0x9F) are copied. `own_o` stays high for exactly 640 clocks, counted from the first read clock. It then falls and the engine is idle.
- R7: A write on `reg_wr_i` while `own_o` is high returns the engine to waiting. On the next clock no strobe is high. The copy then restarts at index 0 from the new page, again aligned to phase 3.
- R8: `bus_wr_o` is never high.
- R9: `bus_rd_o` and `oam_wr_o` are never high in the same clock, and neither is high while `own_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 2 | Shared machine cycle phase, 0..3 |
| reg_wr_i | input | 1 | CPU write strobe for the start register |
| reg_wdata_i | input | 8 | Source page written by the CPU |
| reg_rdata_o | output | 8 | Start register readback |
| bus_din_i | input | 8 | Data returned by the shared bus |
| bus_addr_o | output | 16 | Shared bus read address |
| bus_rd_o | output | 1 | Shared bus read strobe |
| bus_wr_o | output | 1 | Shared bus write strobe, held low |
| oam_addr_o | output | 16 | Attribute memory write address |
| oam_wdata_o | output | 8 | Attribute memory write data |
| oam_wr_o | output | 1 | Attribute memory write strobe |
| own_o | output | 1 | Engine owns the shared bus and attribute memory |

## Verification
A start-register write can land in the same clock as a byte step that is already in progress. The retrigger must then win over the step: the counter clears, and no strobe is issued on the following clock. The bench provokes this by writing a new page after a random delay in the middle of a copy, so the write falls on every kind of step. It judges the result in three ways: there are no strobes one clock later, the first attribute write after the restart lands at 0xFE00, and all 160 bytes end up matching the new page.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_RD,
    S_CAP,
    S_WR,
    S_HOLD
  } dma_state_e;
endpackage

// File: rtl/sprite_dma_page.sv
module sprite_dma_page #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_o <= '0;
    else if (wr_i) page_o <= wdata_i;
  end
endmodule

// File: rtl/sprite_dma_index.sv
module sprite_dma_index #(
  parameter int unsigned LEN  = 160,
  localparam int unsigned IW  = $clog2(LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_o <= '0;
    else if (clr_i)   idx_o <= '0;
    else if (inc_i)   idx_o <= idx_o + 1'b1;
  end

  assign last_o = (idx_o == LAST);

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o <= LAST); // R6
endmodule

// File: rtl/sprite_dma_fsm.sv
module sprite_dma_fsm
  import sprite_dma_pkg::*;
#(
  parameter logic [1:0] START_PHASE = 2'd3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic [1:0] phase_i,
  input  logic       last_i,
  output dma_state_e state_o,
  output logic       clr_o,
  output logic       inc_o
);
  dma_state_e state_d;

  always_comb begin
    state_d = state_o;
    inc_o   = 1'b0;
    clr_o   = trig_i;
    if (trig_i) begin
      state_d = S_WAIT;  // retrigger wins over any step
    end else begin
      unique case (state_o)
        S_IDLE: state_d = S_IDLE;
        S_WAIT: if (phase_i == START_PHASE) state_d = S_RD;
        S_RD:   state_d = S_CAP;
        S_CAP:  state_d = S_WR;
        S_WR:   state_d = S_HOLD;
        S_HOLD: begin
          if (last_i) state_d = S_IDLE;
          else begin
            state_d = S_RD;
            inc_o   = 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= S_IDLE;
    else         state_o <= state_d;
  end

  AST_START_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_RD && $past(state_o) == S_WAIT) |-> ($past(phase_i) == START_PHASE)); // R3
  AST_WR_AFTER_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_WR) |-> ($past(state_o) == S_CAP)); // R4
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprite_dma_pkg::*;
#(
  parameter int unsigned  LEN         = 160,
  parameter logic [15:0]  DEST_BASE   = 16'hFE00,
  parameter logic [1:0]   START_PHASE = 2'd3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  phase_i,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic [7:0]  bus_din_i,
  output logic [15:0] bus_addr_o,
  output logic        bus_rd_o,
  output logic        bus_wr_o,
  output logic [15:0] oam_addr_o,
  output logic [7:0]  oam_wdata_o,
  output logic        oam_wr_o,
  output logic        own_o
);
  localparam int unsigned IW = $clog2(LEN);

  dma_state_e     state;
  logic           clr, inc, last;
  logic [IW-1:0]  idx;
  logic [7:0]     page;
  logic [7:0]     data_q;

  sprite_dma_page #(.PW(8)) u_page (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .page_o(page)
  );

  sprite_dma_index #(.LEN(LEN)) u_idx (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(inc), .idx_o(idx), .last_o(last)
  );

  sprite_dma_fsm #(.START_PHASE(START_PHASE)) u_fsm (
    .clk_i, .rst_ni, .trig_i(reg_wr_i), .phase_i, .last_i(last),
    .state_o(state), .clr_o(clr), .inc_o(inc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              data_q <= '0;
    else if (state == S_CAP)  data_q <= bus_din_i;
  end

  assign reg_rdata_o = page;
  assign own_o       = (state != S_IDLE);
  assign bus_rd_o    = (state == S_RD) || (state == S_CAP);
  assign bus_wr_o    = 1'b0;
  assign bus_addr_o  = {page, 8'(idx)};
  assign oam_wr_o    = (state == S_WR);
  assign oam_addr_o  = DEST_BASE + 16'(idx);
  assign oam_wdata_o = data_q;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && oam_wr_o)); // R9
  AST_STROBE_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || oam_wr_o) |-> own_o); // R9
  AST_RETRIGGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && own_o) |=> (idx == '0 && !bus_rd_o && !oam_wr_o && own_o)); // R7
  AST_TRIG_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> (own_o && reg_rdata_o == $past(reg_wdata_i))); // R2
endmodule

// File: tb/sprite_dma_test.sv
module sprite_dma_test;
  localparam time TCLK = 10ns;
  localparam int  LEN  = 160;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  phase_i = 2'd0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_wdata_i = 8'h00;
  logic [7:0]  reg_rdata_o;
  logic [7:0]  bus_din_i;
  logic [15:0] bus_addr_o;
  logic        bus_rd_o, bus_wr_o, oam_wr_o, own_o;
  logic [15:0] oam_addr_o;
  logic [7:0]  oam_wdata_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] salt = 8'h5A;
  logic [7:0] model [LEN];
  int  n_wr = 0;
  int  first_wr_addr = -1;
  bit  saw_ext_wr = 0;
  bit  saw_bad_strobe = 0;

  sprite_dma uut (
    .clk_i, .rst_ni, .phase_i, .reg_wr_i, .reg_wdata_i, .reg_rdata_o,
    .bus_din_i, .bus_addr_o, .bus_rd_o, .bus_wr_o,
    .oam_addr_o, .oam_wdata_o, .oam_wr_o, .own_o
  );

  function automatic logic [7:0] src_byte(input logic [15:0] a, input logic [7:0] s);
    return (a[7:0] * 8'd7) ^ (a[15:8] + s) ^ {a[3:0], a[7:4]};
  endfunction

  assign bus_din_i = src_byte(bus_addr_o, salt);

  always #(TCLK/2) clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_i <= 2'd0;
    else         phase_i <= phase_i + 2'd1;
  end

  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (bus_wr_o) saw_ext_wr <= 1'b1;
      if ((bus_rd_o && oam_wr_o) || ((bus_rd_o || oam_wr_o) && !own_o)) saw_bad_strobe <= 1'b1;
      if (oam_wr_o) begin
        if (first_wr_addr < 0) first_wr_addr = int'(oam_addr_o);
        if (oam_addr_o >= 16'hFE00 && oam_addr_o < 16'hFE00 + LEN)
          model[oam_addr_o - 16'hFE00] = oam_wdata_o;
        n_wr++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic trigger(input logic [7:0] p);
    @(negedge clk_i);
    reg_wr_i = 1'b1;
    reg_wdata_i = p;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    check(own_o == 1'b1, "R2 own", int'(own_o), 1);
    check(reg_rdata_o == p, "R2 readback", int'(reg_rdata_o), int'(p));
  endtask

  // waits for the first read strobe, then counts owned clocks until release
  task automatic finish_copy(input logic [7:0] p, input bit check_len);
    int guard = 0;
    int owned = 0;
    int mism = 0;
    while (!bus_rd_o && guard < 100) begin
      @(negedge clk_i);
      guard++;
    end
    check(bus_rd_o && phase_i == 2'd0, "R3 start phase", int'(phase_i), 0);
    check(bus_addr_o == {p, 8'h00}, "R4 first read addr", int'(bus_addr_o), int'({p, 8'h00}));
    while (own_o && owned < 5000) begin
      @(negedge clk_i);
      owned++;
    end
    if (check_len) check(owned == 4 * LEN, "R6 owned clocks", owned, 4 * LEN);
    check(!bus_rd_o && !oam_wr_o, "R6 idle after copy", int'({bus_rd_o, oam_wr_o}), 0);
    for (int i = 0; i < LEN; i++)
      if (model[i] !== src_byte({p, 8'(i)}, salt)) mism++;
    check(mism == 0, "R4 R5 copied contents", mism, 0);
  endtask

  task automatic clear_model();
    for (int i = 0; i < LEN; i++) model[i] = 8'hxx;
    n_wr = 0;
    first_wr_addr = -1;
  endtask

  initial begin
    void'($urandom(32'h1D2C));
    repeat (3) @(negedge clk_i);
    check(!own_o && !bus_rd_o && !bus_wr_o && !oam_wr_o, "R1 reset strobes",
          int'({own_o, bus_rd_o, bus_wr_o, oam_wr_o}), 0);
    check(reg_rdata_o == 8'h00, "R1 reset readback", int'(reg_rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed: page 0xC1
    clear_model();
    trigger(8'hC1);
    finish_copy(8'hC1, 1'b1);
    check(n_wr == LEN, "R6 write count", n_wr, LEN);
    check(first_wr_addr == 16'hFE00, "R5 first dest", first_wr_addr, 16'hFE00);

    // random pages, salts and phase offsets
    for (int t = 0; t < 5; t++) begin
      logic [7:0] p;
      p = 8'($urandom);
      salt = 8'($urandom);
      repeat ($urandom_range(0, 7)) @(negedge clk_i);
      clear_model();
      trigger(p);
      finish_copy(p, 1'b1);
    end

    // retrigger mid copy at random step
    for (int t = 0; t < 3; t++) begin
      logic [7:0] pa, pb;
      pa = 8'($urandom);
      pb = pa ^ 8'h3C;
      clear_model();
      trigger(pa);
      repeat ($urandom_range(5, 300)) @(negedge clk_i);
      @(negedge clk_i);
      reg_wr_i = 1'b1;
      reg_wdata_i = pb;
      @(negedge clk_i);
      reg_wr_i = 1'b0;
      check(own_o && !bus_rd_o && !oam_wr_o, "R7 back to wait",
            int'({own_o, bus_rd_o, oam_wr_o}), 4);
      first_wr_addr = -1;
      n_wr = 0;
      finish_copy(pb, 1'b1);
      check(first_wr_addr == 16'hFE00, "R7 restart index", first_wr_addr, 16'hFE00);
      check(n_wr == LEN, "R7 full recopy", n_wr, LEN);
    end

    // retrigger during the wait state itself
    clear_model();
    trigger(8'h80);
    trigger(8'h81);
    finish_copy(8'h81, 1'b1);

    check(!saw_ext_wr, "R8 no shared bus write", int'(saw_ext_wr), 0);
    check(!saw_bad_strobe, "R9 strobe exclusivity", int'(saw_bad_strobe), 0);
    finish_run();
  end
endmodule